// File: doc/BRIEF.md
# Bit Matrix Multiply Unit

The unit holds a square bit matrix in registers and multiplies a bit vector by it. Each result row is produced from the AND of the vector with one stored matrix row. Three reductions are available over that AND. The OR reduction gives sum-of-products logic and, with a permutation matrix, any bit shuffle. The XOR reduction gives parity, which suits XOR-based hashing. The population count reduction returns the number of matching bits in each row.

Software loads the matrix one row per cycle through a write port that takes a row address. A multiply request supplies the vector and the reduction mode. The unit then walks the matrix eight rows per cycle and raises a one-cycle done pulse once the whole result is valid. The result stays on the output until the next request is accepted.

With the default parameters the vector is 64 bits and the matrix is 64x64. A count result packs 64 fields of 8 bits into 512 bits. The field width must be able to hold the row width.

Top module: `bmm_unit`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low and `result_o` is all zero.
- R2: With mode 0 (OR), bit i of `result_o` is 1 exactly when some bit j has both `vec_i[j]` and matrix row i bit j set. Bits 64 to 511 are zero.
- R3: With mode 1 (XOR), bit i of `result_o` is the parity of the bitwise AND of `vec_i` and matrix row i. Bits 64 to 511 are zero.
- R4: With mode 2 (COUNT), bits [8i+7:8i] of `result_o` hold the number of set bits in the AND of `vec_i` and row i. A full count of 64 reads as 0x40, with no saturation.
- R5: Mode 3 is reserved and yields an all-zero `result_o` at done.
- R6: A request is accepted on a clock edge where `start_i` is high and `busy_o` is low. `busy_o` is high from the next cycle on, and `done_o` is high for exactly one cycle, 8 edges after the accepting edge. `busy_o` is low in that cycle.
- R7: The write `wr_data_i` to row `wr_row_i` takes effect when `wr_en_i` is high and `busy_o` is low. A write while `busy_o` is high leaves the matrix unchanged.
- R8: `start_i` while busy is ignored. `vec_i` and `mode_i` are captured at the accepting edge, so changes to them later do not alter the running result or its timing.
- R9: A matrix with one set bit per row and per column, used in OR mode, permutes the vector: result bit i equals `vec_i[p(i)]`, where p(i) is the column set in row i.
- R10: After done, `result_o` holds its value until the next request is accepted, whatever `vec_i` and `mode_i` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Matrix row write enable |
| wr_row_i | input | 6 | Row address for the write |
| wr_data_i | input | 64 | Row contents to write |
| start_i | input | 1 | Multiply request |
| vec_i | input | 64 | Vector operand, captured when a request is accepted |
| mode_i | input | 2 | Reduction: 0 OR, 1 XOR, 2 COUNT, 3 reserved |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | One-cycle pulse when the result is complete |
| result_o | output | 512 | Result: 64 bits in OR and XOR modes, 64 x 8-bit counts in COUNT mode |

## Verification
The hardest cases to reach are those that fall inside the eight-cycle window of a running multiply. These are a row write arriving while busy, and a second request carrying a different vector and mode. The bench drives both at chosen cycles of a running multiply. It then exposes the matrix through a later all-ones COUNT multiply, which reports every row's population. The saturation boundary is reached by loading an all-ones matrix and vector, so every field must read exactly 64.

// File: rtl/bmm_pkg.sv
`timescale 1ns/1ps
package bmm_pkg;
  typedef enum logic [1:0] {
    RED_OR  = 2'd0,
    RED_XOR = 2'd1,
    RED_CNT = 2'd2,
    RED_RSV = 2'd3
  } red_mode_t;
endpackage

// File: rtl/bmm_store.sv
`timescale 1ns/1ps
module bmm_store #(
  parameter int VEC_W = 64,
  parameter int LANES = 8,
  localparam int RAW  = $clog2(VEC_W),
  localparam int LW   = $clog2(LANES),
  localparam int GW   = RAW - LW
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [RAW-1:0]                   wr_row_i,
  input  logic [VEC_W-1:0]                 wr_data_i,
  input  logic                             busy_i,
  input  logic [GW-1:0]                    grp_i,
  output logic [LANES-1:0][VEC_W-1:0]      rows_o
);
  logic [VEC_W-1:0][VEC_W-1:0] mem_q, mem_d;
  logic                        wr_ok;

  // a write is taken only while no multiply reads the matrix
  assign wr_ok = wr_en_i & ~busy_i;

  always_comb begin
    mem_d = mem_q;
    if (wr_ok) mem_d[wr_row_i] = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mem_q <= '0;
    else if (wr_ok)  mem_q <= mem_d;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign rows_o[l] = mem_q[{grp_i, LW'(l)}];
  end

  p_write_blocked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(mem_q));
endmodule

// File: rtl/bmm_row_reduce.sv
`timescale 1ns/1ps
module bmm_row_reduce
  import bmm_pkg::*;
#(
  parameter int VEC_W = 64,
  parameter int CNT_W = 8
) (
  input  logic [VEC_W-1:0] terms_i,
  input  red_mode_t        mode_i,
  output logic [CNT_W-1:0] field_o
);
  logic [CNT_W-1:0] cnt;
  logic             any;

  // one counter tree serves all modes: its lowest bit is the parity
  always_comb begin
    cnt = '0;
    for (int j = 0; j < VEC_W; j++) cnt = cnt + CNT_W'(terms_i[j]);
  end

  assign any = |terms_i;

  always_comb begin
    unique case (mode_i)
      RED_OR:  field_o = CNT_W'(any);
      RED_XOR: field_o = CNT_W'(cnt[0]);
      RED_CNT: field_o = cnt;
      default: field_o = '0;
    endcase
  end

  always_comb begin
    p_or_count_r2: assert (any == (cnt != '0));
  end
endmodule

// File: rtl/bmm_seq.sv
`timescale 1ns/1ps
module bmm_seq #(
  parameter int GROUPS = 8,
  localparam int GW    = $clog2(GROUPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [GW-1:0] grp_o
);
  logic          busy_q, busy_d, done_q, done_d;
  logic [GW-1:0] grp_q, grp_d;
  logic          step_en;

  assign accept_o = start_i & ~busy_q;
  assign step_en  = accept_o | busy_q | done_q;

  always_comb begin
    busy_d = busy_q;
    grp_d  = grp_q;
    done_d = 1'b0;
    if (accept_o) begin
      busy_d = 1'b1;
      grp_d  = '0;
    end else if (busy_q) begin
      if (grp_q == GW'(GROUPS - 1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        grp_d = grp_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      grp_q  <= '0;
    end else if (step_en) begin
      busy_q <= busy_d;
      done_q <= done_d;
      grp_q  <= grp_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign grp_o  = grp_q;

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_accept_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> busy_o && grp_o == '0);
  p_done_ends_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));
  p_no_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && grp_o != GW'(GROUPS - 1) |=> busy_o && grp_o == $past(grp_o) + 1'b1);
endmodule

// File: rtl/bmm_unit.sv
`timescale 1ns/1ps
module bmm_unit
  import bmm_pkg::*;
#(
  parameter int VEC_W  = 64,
  parameter int LANES  = 8,
  parameter int CNT_W  = 8,
  localparam int RAW    = $clog2(VEC_W),
  localparam int GROUPS = VEC_W / LANES,
  localparam int GW     = $clog2(GROUPS),
  localparam int RES_W  = VEC_W * CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [RAW-1:0]   wr_row_i,
  input  logic [VEC_W-1:0] wr_data_i,
  input  logic             start_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [1:0]       mode_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic                          accept;
  logic [GW-1:0]                 grp;
  logic [LANES-1:0][VEC_W-1:0]   rows;
  logic [LANES-1:0][CNT_W-1:0]   lane_field;
  logic [VEC_W-1:0]              vec_q;
  red_mode_t                     mode_q;
  logic [VEC_W-1:0][CNT_W-1:0]   res_q, res_d;
  logic                          res_en;

  bmm_seq #(.GROUPS(GROUPS)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .grp_o    (grp)
  );

  bmm_store #(.VEC_W(VEC_W), .LANES(LANES)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_row_i  (wr_row_i),
    .wr_data_i (wr_data_i),
    .busy_i    (busy_o),
    .grp_i     (grp),
    .rows_o    (rows)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    bmm_row_reduce #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_red (
      .terms_i (rows[l] & vec_q),
      .mode_i  (mode_q),
      .field_o (lane_field[l])
    );
  end

  // operand capture
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      mode_q <= RED_OR;
    end else if (accept) begin
      vec_q  <= vec_i;
      mode_q <= red_mode_t'(mode_i);
    end
  end

  // result fields: cleared on accept, one group of rows filled per busy cycle
  assign res_en = accept | busy_o;

  always_comb begin
    res_d = res_q;
    if (accept) begin
      res_d = '0;
    end else if (busy_o) begin
      for (int r = 0; r < VEC_W; r++) begin
        if (r / LANES == int'(grp)) res_d[r] = lane_field[r % LANES];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  always_comb begin
    result_o = '0;
    for (int r = 0; r < VEC_W; r++) begin
      if (mode_q == RED_CNT) result_o[r*CNT_W +: CNT_W] = res_q[r];
      else                   result_o[r]                = res_q[r][0];
    end
  end

  p_rsv_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o && mode_q == RED_RSV |-> result_o == '0);
  p_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o && mode_q != RED_CNT |-> result_o[RES_W-1:VEC_W] == '0);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !busy_o && !accept |=> $stable(result_o));

  for (genvar r = 0; r < VEC_W; r++) begin : g_bound
    p_field_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
      res_q[r] <= CNT_W'(VEC_W));
  end
endmodule

// File: tb/sim_bmm_unit.sv
`timescale 1ns/1ps
module sim_bmm_unit;
  localparam int N = 64;
  localparam int RW = 512;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          wr_en_i;
  logic [5:0]    wr_row_i;
  logic [N-1:0]  wr_data_i;
  logic          start_i;
  logic [N-1:0]  vec_i;
  logic [1:0]    mode_i;
  logic          busy_o;
  logic          done_o;
  logic [RW-1:0] result_o;

  int checks   = 0;
  int failures = 0;
  bit ended    = 0;
  logic [N-1:0] m [N];
  logic [63:0]  seed = 64'h9E3779B97F4A7C15;

  always #4 clk = ~clk;

  bmm_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_row_i(wr_row_i),
    .wr_data_i(wr_data_i), .start_i(start_i), .vec_i(vec_i), .mode_i(mode_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd();
    seed ^= seed << 13;
    seed ^= seed >> 7;
    seed ^= seed << 17;
    return seed;
  endfunction

  function automatic logic [RW-1:0] expect_res(input logic [N-1:0] v, input logic [1:0] md);
    logic [RW-1:0] e = '0;
    for (int r = 0; r < N; r++) begin
      case (md)
        2'd0: e[r] = |(m[r] & v);
        2'd1: e[r] = ^(m[r] & v);
        2'd2: e[r*8 +: 8] = 8'($countones(m[r] & v));
        default: ;
      endcase
    end
    return e;
  endfunction

  task automatic write_row(input int r, input logic [N-1:0] d);
    wr_en_i = 1'b1; wr_row_i = 6'(r); wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    m[r] = d;
  endtask

  // issue one request and wait for done; checks the R6 timing
  task automatic run(input logic [N-1:0] v, input logic [1:0] md, output logic [RW-1:0] res);
    int n;
    vec_i = v; mode_i = md; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1 && done_o === 1'b0, "R6", "busy after accept", {busy_o, done_o}, 2'b10);
    n = 0;
    while (done_o !== 1'b1 && n < 20) begin @(negedge clk); n++; end
    chk(n == 8, "R6", "edges to done", n, 8);
    chk(busy_o === 1'b0, "R6", "busy low at done", busy_o, 0);
    res = result_o;
    @(negedge clk);
    chk(done_o === 1'b0, "R6", "done single cycle", done_o, 0);
  endtask

  task automatic t_reset();
    chk(busy_o === 1'b0 && done_o === 1'b0, "R1", "flags after reset", {busy_o, done_o}, 0);
    chk(result_o === '0, "R1", "result after reset", result_o, 0);
  endtask

  task automatic t_or_mode();
    logic [RW-1:0] r;
    for (int i = 0; i < N; i++) write_row(i, rnd() & rnd() & rnd());
    for (int k = 0; k < 3; k++) begin
      logic [N-1:0] v = (k == 0) ? 64'h1 : rnd() & rnd();
      run(v, 2'd0, r);
      chk(r === expect_res(v, 2'd0), "R2", "OR result", r, expect_res(v, 2'd0));
    end
  endtask

  task automatic t_xor_mode();
    logic [RW-1:0] r;
    for (int i = 0; i < N; i++) write_row(i, rnd());
    for (int k = 0; k < 3; k++) begin
      logic [N-1:0] v = rnd();
      run(v, 2'd1, r);
      chk(r === expect_res(v, 2'd1), "R3", "XOR result", r, expect_res(v, 2'd1));
    end
  endtask

  task automatic t_cnt_mode();
    logic [RW-1:0] r;
    logic [N-1:0]  v = rnd();
    run(v, 2'd2, r);
    chk(r === expect_res(v, 2'd2), "R4", "COUNT random", r, expect_res(v, 2'd2));
    for (int i = 0; i < N; i++) write_row(i, '1);
    run('1, 2'd2, r);
    chk(r === {64{8'h40}}, "R4", "COUNT full 64", r, {64{8'h40}});
  endtask

  task automatic t_reserved();
    logic [RW-1:0] r;
    run('1, 2'd3, r);
    chk(r === '0, "R5", "reserved mode", r, 0);
  endtask

  task automatic t_perm();
    logic [RW-1:0] r;
    logic [RW-1:0] e;
    logic [N-1:0]  v = rnd();
    for (int i = 0; i < N; i++) write_row(i, 64'h1 << ((5 * i + 3) % N));
    e = '0;
    for (int i = 0; i < N; i++) e[i] = v[(5 * i + 3) % N];
    run(v, 2'd0, r);
    chk(r === e, "R9", "permutation", r, e);
  endtask

  task automatic t_write_blocked();
    logic [RW-1:0] r;
    int n;
    for (int i = 0; i < N; i++) write_row(i, rnd());
    vec_i = rnd(); mode_i = 2'd0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    wr_en_i = 1'b1; wr_row_i = 6'd5; wr_data_i = ~m[5];
    @(negedge clk);
    wr_en_i = 1'b0;
    n = 0;
    while (done_o !== 1'b1 && n < 20) begin @(negedge clk); n++; end
    @(negedge clk);
    run('1, 2'd2, r);
    chk(r === expect_res('1, 2'd2), "R7", "write while busy ignored", r, expect_res('1, 2'd2));
    write_row(5, ~m[5]);
    run('1, 2'd2, r);
    chk(r === expect_res('1, 2'd2), "R7", "write while idle lands", r, expect_res('1, 2'd2));
  endtask

  task automatic t_start_ignored();
    logic [N-1:0] v1 = rnd();
    int n;
    vec_i = v1; mode_i = 2'd2; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    repeat (3) begin @(negedge clk); n++; end
    vec_i = rnd(); mode_i = 2'd0; start_i = 1'b1;
    @(negedge clk); n++;
    start_i = 1'b0;
    while (done_o !== 1'b1 && n < 20) begin @(negedge clk); n++; end
    chk(n == 8, "R8", "done timing with late start", n, 8);
    chk(result_o === expect_res(v1, 2'd2), "R8", "captured operands", result_o, expect_res(v1, 2'd2));
    @(negedge clk);
    chk(busy_o === 1'b0, "R8", "no second run", busy_o, 0);
  endtask

  task automatic t_hold();
    logic [RW-1:0] r;
    run(rnd(), 2'd1, r);
    vec_i = rnd(); mode_i = 2'd2;
    repeat (4) @(negedge clk);
    chk(result_o === r, "R10", "result held", result_o, r);
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    rst_ni = 1'b0; wr_en_i = 1'b0; wr_row_i = '0; wr_data_i = '0;
    start_i = 1'b0; vec_i = '0; mode_i = '0;
    for (int i = 0; i < N; i++) m[i] = '0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_or_mode();
    t_xor_mode();
    t_cnt_mode();
    t_reserved();
    t_perm();
    t_write_blocked();
    t_start_ignored();
    t_hold();
    finish_up();
  end

  initial begin
    #(8 * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_up();
  end
endmodule